// File: doc/BRIEF.md
# Streaming Decimal Literal Recognizer

This block watches a stream of 8-bit ASCII characters, one for each clock edge at which the character strobe is high. It decides whether the stream spells a decimal floating-point literal. A valid literal has this shape: optional leading blanks, an optional sign, integer digits, an optional fraction that starts with a point, and an optional exponent that starts with a lower-case `e`. A blank ends the literal. The block keeps a 3-bit state that anyone can see. It raises an ok flag once a complete literal has been seen. It raises an error flag as soon as a character cannot continue the literal.

The next state comes from a pure lookup on the current character class and the current state, as a ROM or PLA would provide. That lookup also produces the ok and error flags, which are registered together with the state. The input side has a plain strobe and no back-pressure. The block accepts every strobed character in the cycle it is presented, so an upstream source never has to wait. A synchronous reset starts a new literal.

Top module: `numlit_recognizer`

## Requirements
- R1: The state output uses a fixed encoding: start=000, sign=001, whole=010, frac=011, exp=100, done=101, error=110. The value 111 never appears.
- R2: While the synchronous reset is high at a clock edge, the state becomes start and both flags are low after that edge. Reset takes priority over a strobed character.
- R3: At an edge where the character strobe is low, the state and both flags keep their values, whatever the character input holds.
- R4: From start: blank (0x20) stays in start, a digit (0x30–0x39) goes to whole, '+' (0x2B) or '-' (0x2D) goes to sign, and '.' (0x2E) goes to frac.
- R5: From sign: a digit goes to whole and '.' goes to frac.
- R6: From whole: a digit stays in whole, '.' goes to frac, 'e' (0x65) goes to exp, and a blank goes to done.
- R7: From frac: a digit stays in frac, 'e' goes to exp, and a blank goes to done.
- R8: From exp: a digit stays in exp and a blank goes to done. A sign after 'e' is not accepted.
- R9: Any character and state pair not listed in R4–R8 moves the state to error. This includes tab (0x09) and upper-case 'E' (0x45).
- R10: Error is absorbing. Any strobed character leaves the state in error until reset.
- R11: Done is absorbing. Any strobed character leaves the state in done until reset.
- R12: The ok output is high exactly when the state is done. The error output is high exactly when the state is error. Each change one clock edge after the strobed character that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | 1 | Character strobe; the character is consumed at this edge |
| ch_data | input | 8 | ASCII character |
| lit_ok | output | 1 | High while the recognizer is in done |
| lit_err | output | 1 | High while the recognizer is in error |
| lit_state | output | 3 | Current recognizer state, encoded as in R1 |

## Verification
The assertions check on every cycle that both terminal states are absorbing and that the state holds when there is no strobe. They also check that the registered flags agree with the state, that the unused code 111 never shows, that reset lands in start, and that a digit in the exponent keeps the state in exp. Only the bench's character streams can show that each row of the transition table sends a given character class to the right state. The streams include well-formed literals, literals with missing parts, doubled points, foreign letters, tabs, an upper-case exponent marker and a signed exponent. Only directed tests can show that reset wins over a strobed character, and that reset recovers a machine stuck in error.

// File: rtl/numlit_pkg.sv
package numlit_pkg;
  localparam int CHAR_W  = 8;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_START = 3'b000,
    ST_SIGN  = 3'b001,
    ST_WHOLE = 3'b010,
    ST_FRAC  = 3'b011,
    ST_EXP   = 3'b100,
    ST_DONE  = 3'b101,
    ST_ERROR = 3'b110
  } lit_state_e;

  typedef enum logic [2:0] {
    CC_BLANK,
    CC_DIGIT,
    CC_SIGN,
    CC_POINT,
    CC_EXPO,
    CC_OTHER
  } char_class_e;

  localparam logic [CHAR_W-1:0] CODE_BLANK = 8'h20;
  localparam logic [CHAR_W-1:0] CODE_PLUS  = 8'h2B;
  localparam logic [CHAR_W-1:0] CODE_MINUS = 8'h2D;
  localparam logic [CHAR_W-1:0] CODE_POINT = 8'h2E;
  localparam logic [CHAR_W-1:0] CODE_ZERO  = 8'h30;
  localparam logic [CHAR_W-1:0] CODE_NINE  = 8'h39;
  localparam logic [CHAR_W-1:0] CODE_EXPO  = 8'h65;
endpackage

// File: rtl/numlit_char_class.sv
module numlit_char_class
  import numlit_pkg::*;
#(
  parameter int W = CHAR_W
) (
  input  logic [W-1:0] ch,
  output char_class_e  cls
);
  logic is_digit;
  logic is_sign;

  assign is_digit = (ch >= W'(CODE_ZERO)) && (ch <= W'(CODE_NINE));
  assign is_sign  = (ch == W'(CODE_PLUS)) || (ch == W'(CODE_MINUS));

  always_comb begin
    if (is_digit)                    cls = CC_DIGIT;
    else if (is_sign)                cls = CC_SIGN;
    else if (ch == W'(CODE_BLANK))   cls = CC_BLANK;
    else if (ch == W'(CODE_POINT))   cls = CC_POINT;
    else if (ch == W'(CODE_EXPO))    cls = CC_EXPO;
    else                             cls = CC_OTHER;
  end

  always_comb begin
    if (is_digit) assert_class_exclusive_R9: assert (!is_sign);
  end
endmodule

// File: rtl/numlit_next_state.sv
module numlit_next_state
  import numlit_pkg::*;
(
  input  lit_state_e  cur,
  input  char_class_e cls,
  output lit_state_e  nxt,
  output logic        nxt_ok,
  output logic        nxt_err
);
  always_comb begin
    nxt = ST_ERROR;
    unique case (cur)
      ST_START: begin
        case (cls)
          CC_BLANK: nxt = ST_START;
          CC_DIGIT: nxt = ST_WHOLE;
          CC_SIGN:  nxt = ST_SIGN;
          CC_POINT: nxt = ST_FRAC;
          default:  nxt = ST_ERROR;
        endcase
      end
      ST_SIGN: begin
        case (cls)
          CC_DIGIT: nxt = ST_WHOLE;
          CC_POINT: nxt = ST_FRAC;
          default:  nxt = ST_ERROR;
        endcase
      end
      ST_WHOLE: begin
        case (cls)
          CC_DIGIT: nxt = ST_WHOLE;
          CC_POINT: nxt = ST_FRAC;
          CC_EXPO:  nxt = ST_EXP;
          CC_BLANK: nxt = ST_DONE;
          default:  nxt = ST_ERROR;
        endcase
      end
      ST_FRAC: begin
        case (cls)
          CC_DIGIT: nxt = ST_FRAC;
          CC_EXPO:  nxt = ST_EXP;
          CC_BLANK: nxt = ST_DONE;
          default:  nxt = ST_ERROR;
        endcase
      end
      ST_EXP: begin
        case (cls)
          CC_DIGIT: nxt = ST_EXP;
          CC_BLANK: nxt = ST_DONE;
          default:  nxt = ST_ERROR;
        endcase
      end
      ST_DONE:  nxt = ST_DONE;
      ST_ERROR: nxt = ST_ERROR;
      default:  nxt = ST_ERROR;
    endcase
  end

  assign nxt_ok  = (nxt == ST_DONE);
  assign nxt_err = (nxt == ST_ERROR);

  always_comb begin
    if (cur == ST_ERROR) assert_error_row_closed_R10: assert (nxt == ST_ERROR);
    if (cur == ST_DONE)  assert_done_row_closed_R11: assert (nxt == ST_DONE);
  end
endmodule

// File: rtl/numlit_recognizer.sv
module numlit_recognizer
  import numlit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ch_valid,
  input  logic [CHAR_W-1:0]  ch_data,
  output logic               lit_ok,
  output logic               lit_err,
  output logic [STATE_W-1:0] lit_state
);
  char_class_e cls;
  lit_state_e  state_q;
  lit_state_e  state_d;
  logic        ok_d, err_d;
  logic        ok_q, err_q;

  numlit_char_class #(.W(CHAR_W)) u_class (
    .ch  (ch_data),
    .cls (cls)
  );

  numlit_next_state u_table (
    .cur     (state_q),
    .cls     (cls),
    .nxt     (state_d),
    .nxt_ok  (ok_d),
    .nxt_err (err_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_START;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else if (ch_valid) begin
      state_q <= state_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign lit_state = state_q;
  assign lit_ok    = ok_q;
  assign lit_err   = err_q;

  assert_reset_start_R2: assert property (@(posedge clk)
    rst |=> (lit_state == 3'b000 && !lit_ok && !lit_err));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !ch_valid |=> ($stable(lit_state) && $stable(lit_ok) && $stable(lit_err)));

  assert_exp_digit_R8: assert property (@(posedge clk) disable iff (rst)
    (lit_state == 3'b100 && ch_valid && ch_data >= 8'h30 && ch_data <= 8'h39)
      |=> lit_state == 3'b100);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    lit_err |=> (lit_err && lit_state == 3'b110));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    lit_ok |=> (lit_ok && lit_state == 3'b101));

  assert_no_code7_R1: assert property (@(posedge clk) disable iff (rst)
    lit_state != 3'b111);

  assert_flags_track_R12: assert property (@(posedge clk) disable iff (rst)
    (lit_ok == (lit_state == 3'b101)) && (lit_err == (lit_state == 3'b110)));
endmodule

// File: tb/numlit_recognizer_tb_top.sv
`timescale 1ns/1ps
module numlit_recognizer_tb_top;
  localparam logic [2:0] S_START = 3'b000;
  localparam logic [2:0] S_SIGN  = 3'b001;
  localparam logic [2:0] S_WHOLE = 3'b010;
  localparam logic [2:0] S_FRAC  = 3'b011;
  localparam logic [2:0] S_EXP   = 3'b100;
  localparam logic [2:0] S_DONE  = 3'b101;
  localparam logic [2:0] S_ERR   = 3'b110;

  localparam int NV = 16;
  localparam logic [127:0] VEC_TXT [NV] = '{
    "  +123.456e23 ", ".456 ", "-123 ", "1.5e5 ",
    "12a", "+ ", "1..2", "7 x9",
    "3e ", "1\t", "2E5 ", "-. ",
    "5.e", "e1 ", "+-1", "1e+5 "
  };
  localparam logic [2:0] VEC_END [NV] = '{
    S_DONE, S_DONE, S_DONE, S_DONE,
    S_ERR,  S_ERR,  S_ERR,  S_DONE,
    S_DONE, S_ERR,  S_ERR,  S_DONE,
    S_EXP,  S_ERR,  S_ERR,  S_ERR
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ch_valid = 1'b0;
  logic [7:0] ch_data = 8'h00;
  logic       lit_ok, lit_err;
  logic [2:0] lit_state;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;

  always #2.5 clk = ~clk;

  numlit_recognizer dut_i (
    .clk       (clk),
    .rst       (rst),
    .ch_valid  (ch_valid),
    .ch_data   (ch_data),
    .lit_ok    (lit_ok),
    .lit_err   (lit_err),
    .lit_state (lit_state)
  );

  function automatic logic [2:0] ref_step(input logic [2:0] s, input logic [7:0] c);
    bit dig = (c >= "0") && (c <= "9");
    if (s == S_DONE) return S_DONE;
    if (s == S_ERR)  return S_ERR;
    if (s == S_START) begin
      if (c == " ") return S_START;
      if (dig) return S_WHOLE;
      if (c == "+" || c == "-") return S_SIGN;
      if (c == ".") return S_FRAC;
    end else if (s == S_SIGN) begin
      if (dig) return S_WHOLE;
      if (c == ".") return S_FRAC;
    end else if (s == S_WHOLE) begin
      if (dig) return S_WHOLE;
      if (c == ".") return S_FRAC;
      if (c == "e") return S_EXP;
      if (c == " ") return S_DONE;
    end else if (s == S_FRAC) begin
      if (dig) return S_FRAC;
      if (c == "e") return S_EXP;
      if (c == " ") return S_DONE;
    end else if (s == S_EXP) begin
      if (dig) return S_EXP;
      if (c == " ") return S_DONE;
    end
    return S_ERR;
  endfunction

  function automatic string tag_for(input logic [2:0] prev, input logic [2:0] nxt);
    if (prev == S_ERR)  return "R10";
    if (prev == S_DONE) return "R11";
    if (nxt == S_ERR)   return "R9";
    case (prev)
      S_START: return "R4";
      S_SIGN:  return "R5";
      S_WHOLE: return "R6";
      S_FRAC:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_flags(input logic [2:0] exp_state);
    check("R12", {1'b0, lit_ok, lit_err},
          {1'b0, exp_state == S_DONE, exp_state == S_ERR});
  endtask

  task automatic send(input logic [7:0] c, input bit v);
    @(negedge clk);
    ch_valid = v;
    ch_data  = c;
    @(posedge clk);
    #1;
    ch_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    @(posedge clk);
    #1;
    check("R2", lit_state, S_START);
    check_flags(S_START);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [2:0] model;
      model = S_START;
      do_reset();
      for (int b = 15; b >= 0; b--) begin
        logic [7:0] c;
        logic [2:0] prev;
        c = VEC_TXT[v][b*8 +: 8];
        if (c != 8'h00) begin
          prev  = model;
          model = ref_step(model, c);
          send(c, 1'b1);
          check(tag_for(prev, model), lit_state, model);
          check_flags(model);
        end
      end
      // R1: end state of each literal compared against the table encoding
      check("R1", lit_state, VEC_END[v]);
    end

    // R3: strobe low with a character that would otherwise cause an error
    do_reset();
    send("4", 1'b1);
    send("x", 1'b0);
    send("\t", 1'b0);
    check("R3", lit_state, S_WHOLE);
    check_flags(S_WHOLE);
    send(" ", 1'b0);
    check("R3", lit_state, S_WHOLE);

    // R10 then R2: error survives many chars, then reset recovers it
    send("?", 1'b1);
    check("R10", lit_state, S_ERR);
    send("1", 1'b1);
    send(" ", 1'b1);
    check("R10", lit_state, S_ERR);
    do_reset();
    check("R2", lit_state, S_START);
    check_flags(S_START);

    // R2: reset with a strobed digit present takes priority
    @(negedge clk);
    rst = 1'b1;
    ch_valid = 1'b1;
    ch_data = "9";
    @(posedge clk);
    #1;
    rst = 1'b0;
    ch_valid = 1'b0;
    check("R2", lit_state, S_START);

    // R11: done absorbs a foreign character and a further blank
    send("8", 1'b1);
    send(" ", 1'b1);
    check("R11", lit_state, S_DONE);
    send("Z", 1'b1);
    send(".", 1'b1);
    check("R11", lit_state, S_DONE);
    check_flags(S_DONE);

    finish_run();
  end
endmodule